// File: doc/BRIEF.md
# Thread Group Ready Barrier

This block collects "thread ready" events for hardware dispatch and holds them back until a complete group of cooperating threads is ready. It keeps a small table. Each entry is keyed by the instruction address of the loop that spawned a group of threads. An entry also stores the group's member count and a countdown of members that are still missing. A ready event carries the creation address of its thread. That address is compared against every valid entry in parallel.

When the address matches an entry, the countdown of that entry drops by one. The member that brings the countdown to zero releases the whole group: the block emits one enable pulse, tagged with the entry index, and that pulse starts all of the group's accelerators together. The countdown then reloads itself from the member count, so the next round of the same group needs no reprogramming. When the address matches no valid entry, the thread is passed straight through as a single ungrouped dispatch pulse that carries its address.

Entries are written through a plain write port. One write sets the valid flag, the key address and the member count of an entry, and it restarts the countdown of that entry.

Top module: `thread_group_barrier`

## Requirements
- R1: After reset, neither output pulses, and every table entry is invalid, so any ready event is dispatched ungrouped.
- R2: A ready event is compared only against valid entries. When several valid entries hold the same address, the lowest index takes the event.
- R3: A ready event that hits an entry whose countdown is above one decrements that countdown and produces no pulse.
- R4: A ready event that hits an entry whose countdown is one or less raises `grp_en` for exactly one cycle, in the cycle after the event, with `grp_idx` set to that entry's index.
- R5: At the release, the countdown reloads with the member count, so each later release of the same group again needs exactly that many events.
- R6: A ready event that matches no valid entry raises `solo_en` for one cycle, in the cycle after the event, with `solo_addr` equal to the event's address.
- R7: A write loads the valid flag, address and member count of entry `cfg_idx` and sets its countdown to the member count. The write governs events from the next cycle on. A ready event in the same cycle is matched against the table as it stood before the write.
- R8: When a ready event in a cycle hits the entry that is being written in that same cycle, the write takes effect and the event is dropped. Neither output pulses.
- R9: An entry with a member count of zero behaves like a count of one: every hit releases the group.
- R10: `grp_en` and `solo_en` are never high together, and neither is high unless a ready event was presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | Valid flag written to the entry |
| cfg_addr | input | ADDR_W | Creation address written to the entry |
| cfg_size | input | CNT_W | Member count written to the entry |
| rdy_valid | input | 1 | Thread ready event |
| rdy_addr | input | ADDR_W | Creation address of the ready thread |
| grp_en | output | 1 | One-cycle group release pulse |
| grp_idx | output | IDX_W | Entry index of the released group |
| solo_en | output | 1 | One-cycle ungrouped dispatch pulse |
| solo_addr | output | ADDR_W | Address of the ungrouped thread |

## Verification
If a countdown is wrong, the group is released at the wrong member: the pulse comes early, late or never. This becomes visible at the latest when the group has received one full round of member-count events, and the bench checks the outputs after every single event. A corrupted key or valid bit changes the path of an event from a group release to an ungrouped dispatch, or the reverse, one cycle after that event. A failed reload shows up at the first release of the second round. Sweeps run several rounds of every member count, an interleaved pattern across entries, duplicate keys, and writes that collide with ready events. Together they expose each of these faults within a few events.

// File: rtl/thread_group_barrier.sv
module thread_group_barrier #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic              rdy_valid,
  input  logic [ADDR_W-1:0] rdy_addr,
  output logic              grp_en,
  output logic [IDX_W-1:0]  grp_idx,
  output logic              solo_en,
  output logic [ADDR_W-1:0] solo_addr
);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
  logic [ENTRIES-1:0][CNT_W-1:0]  size_q;
  logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q;
  logic [ENTRIES-1:0]             match;
  logic [IDX_W-1:0]               hit_idx;
  logic                           hit, last, drop, take;

  always_comb begin
    hit_idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--)
      if (match[k]) hit_idx = IDX_W'(k);
  end

  assign hit  = |match;
  assign last = cnt_q[hit_idx] <= CNT_W'(1);
  assign drop = cfg_we && (cfg_idx == hit_idx);
  assign take = rdy_valid && hit && !drop;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign match[i] = valid_q[i] && (addr_q[i] == rdy_addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        addr_q[i]  <= '0;
        size_q[i]  <= '0;
        cnt_q[i]   <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(i)) begin
        valid_q[i] <= cfg_valid;
        addr_q[i]  <= cfg_addr;
        size_q[i]  <= cfg_size;
        cnt_q[i]   <= cfg_size;
      end else if (take && hit_idx == IDX_W'(i)) begin
        cnt_q[i] <= last ? size_q[i] : cnt_q[i] - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_en    <= 1'b0;
      grp_idx   <= '0;
      solo_en   <= 1'b0;
      solo_addr <= '0;
    end else begin
      grp_en  <= take && last;
      solo_en <= rdy_valid && !hit;
      if (take && last) grp_idx <= hit_idx;
      if (rdy_valid && !hit) solo_addr <= rdy_addr;
    end
  end

endmodule

module thread_group_barrier_chk #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           rdy_valid,
  input logic [ADDR_W-1:0]              rdy_addr,
  input logic                           grp_en,
  input logic [IDX_W-1:0]               grp_idx,
  input logic                           solo_en,
  input logic [ADDR_W-1:0]              solo_addr,
  input logic [ENTRIES-1:0]             valid_q,
  input logic [ENTRIES-1:0][CNT_W-1:0]  size_q,
  input logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q
);

  // R10
  out_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grp_en && solo_en));

  // R10
  out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rdy_valid) |-> (!grp_en && !solo_en));

  // R6
  solo_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    solo_en |-> solo_addr == $past(rdy_addr));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_en |-> cnt_q[grp_idx] == size_q[grp_idx]);

  // R2
  release_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_en |-> valid_q[grp_idx]);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cnt
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[i] <= size_q[i]);
  end

endmodule

bind thread_group_barrier thread_group_barrier_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_valid(rdy_valid), .rdy_addr(rdy_addr),
  .grp_en(grp_en), .grp_idx(grp_idx), .solo_en(solo_en), .solo_addr(solo_addr),
  .valid_q(valid_q), .size_q(size_q), .cnt_q(cnt_q)
);

// File: tb/test_thread_group_barrier.sv
`timescale 1ns/1ps
module test_thread_group_barrier;
  localparam int ENT = 4;
  localparam int AW  = 12;
  localparam int CW  = 3;
  localparam int IW  = 2;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_valid = 0, rdy_valid = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_addr = '0, rdy_addr = '0;
  logic [CW-1:0] cfg_size = '0;
  logic grp_en, solo_en;
  logic [IW-1:0] grp_idx;
  logic [AW-1:0] solo_addr;

  int checks = 0, errors = 0;
  bit m_v[ENT];
  int m_a[ENT], m_s[ENT], m_c[ENT];

  always #2.5 clk = ~clk;

  thread_group_barrier #(.ENTRIES(ENT), .ADDR_W(AW), .CNT_W(CW)) i_thread_group_barrier (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_addr(cfg_addr), .cfg_size(cfg_size), .rdy_valid(rdy_valid), .rdy_addr(rdy_addr),
    .grp_en(grp_en), .grp_idx(grp_idx), .solo_en(solo_en), .solo_addr(solo_addr));

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int lookup(int a);
    for (int k = 0; k < ENT; k++)
      if (m_v[k] && m_a[k] == a) return k;
    return -1;
  endfunction

  task automatic step(bit wr, int idx, bit v, int a, int s, bit rd, int ra, string tag);
    int h = rd ? lookup(ra) : -1;
    bit eg = 0, es = 0;
    int eidx = 0;
    if (rd) begin
      if (h < 0) es = 1;
      else if (!(wr && h == idx)) begin
        if (m_c[h] <= 1) begin eg = 1; eidx = h; m_c[h] = m_s[h]; end
        else m_c[h]--;
      end
    end
    if (wr) begin m_v[idx] = v; m_a[idx] = a; m_s[idx] = s; m_c[idx] = s; end
    cfg_we = wr; cfg_idx = IW'(idx); cfg_valid = v; cfg_addr = AW'(a); cfg_size = CW'(s);
    rdy_valid = rd; rdy_addr = AW'(ra);
    @(negedge clk);
    cfg_we = 0; rdy_valid = 0;
    check(grp_en == eg, tag, "grp_en", int'(grp_en), int'(eg));
    check(solo_en == es, tag, "solo_en", int'(solo_en), int'(es));
    if (eg) check(grp_idx == IW'(eidx), tag, "grp_idx", int'(grp_idx), eidx);
    if (es) check(solo_addr == AW'(ra), tag, "solo_addr", int'(solo_addr), ra);
  endtask

  task automatic send(int ra, string tag);
    step(0, 0, 0, 0, 0, 1, ra, tag);
  endtask

  task automatic wr(int idx, bit v, int a, int s, string tag);
    step(1, idx, v, a, s, 0, 0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < ENT; k++) begin m_v[k] = 0; m_a[k] = 0; m_s[k] = 0; m_c[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet outputs, empty table
    check(grp_en == 0, "R1", "grp_en", int'(grp_en), 0);
    check(solo_en == 0, "R1", "solo_en", int'(solo_en), 0);
    send('h100, "R1");
    // R6: unmatched addresses pass through
    for (int a = 'h200; a < 'h208; a++) send(a, "R6");
    // R7: program sizes 1..4
    for (int k = 0; k < ENT; k++) wr(k, 1, 'h100 + 16 * k, k + 1, "R7");
    // R3/R4/R5: three rounds per entry
    for (int k = 0; k < ENT; k++)
      for (int n = 0; n < 3 * (k + 1); n++) send('h100 + 16 * k, "R3/R4/R5");
    // R2/R4: interleaved across entries and misses
    for (int n = 0; n < 30; n++) send('h100 + 16 * (n % 5), "R2/R4");
    // R2: duplicate key, lowest index wins
    wr(3, 1, 'h110, 2, "R7");
    for (int n = 0; n < 5; n++) send('h110, "R2");
    // R8: collision on the hit entry drops the event
    step(1, 1, 1, 'h110, 2, 1, 'h110, "R8");
    for (int n = 0; n < 4; n++) send('h110, "R7/R8");
    // R7: write to another entry, ready uses old table
    step(1, 2, 1, 'h130, 2, 1, 'h100, "R7");
    step(1, 0, 1, 'h180, 1, 1, 'h120, "R7");
    send('h120, "R7");
    // R7: rewrite mid-count restarts countdown
    wr(3, 1, 'h140, 4, "R7");
    send('h140, "R7"); send('h140, "R7");
    wr(3, 1, 'h140, 4, "R7");
    for (int n = 0; n < 8; n++) send('h140, "R7/R5");
    // R2: invalidated entry no longer matches
    wr(2, 0, 'h130, 2, "R2");
    for (int n = 0; n < 3; n++) send('h130, "R2");
    // R9: zero member count
    wr(0, 1, 'h150, 0, "R9");
    for (int n = 0; n < 4; n++) send('h150, "R9");
    // R10: back-to-back mixed events
    for (int n = 0; n < 40; n++) send((n % 3 == 0) ? 'h150 : 'h300 + n, "R10");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule